// File: doc/BRIEF.md
# Parallel ADC Conversion and Readout Sequencer

This controller runs a sampling converter over its parallel bus from a synchronous system clock. On request it pulls the active-low convert-start line low for a set number of cycles and then releases it, which launches a conversion. It then waits for the converter's busy flag to go high and come back low. After that it reads a configurable number of result words. Chip-select stays low for the whole burst, and an active-low read strobe is pulsed once for each word. Each word is passed on as a one-cycle valid pulse carrying the data and a channel index, and a done pulse follows the last word.

Several minimum intervals are kept with cycle counters rather than a fixed script: strobe widths, the gap between strobes, a bus-release plus quiet interval after the last read, and an acquisition interval after each conversion. A single request starts one conversion. A continuous-mode level repeats conversions as soon as the intervals allow. If busy does not rise within a bounded window, an error pulse is given and the conversion is abandoned.

A separate single-word register write cycle drives the data bus under chip-select and strobes an active-low write line with its own setup, width and hold counts. Every output is registered. The busy input is assumed to be already synchronous to the system clock.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, convert-start, chip-select, read and write strobes are all high, the bus driver is off, and valid, done and error are low.
- R2: Each convert-start low pulse lasts exactly CONV_LOW cycles before the line returns high.
- R3: If busy is not seen high within BUSY_TO cycles after convert-start rises, a one-cycle error pulse appears exactly BUSY_TO cycles after the rise, no read follows, and the sequencer returns to idle.
- R4: The first read strobe of a burst falls in the cycle right after the sequencer samples busy low.
- R5: Each read strobe stays low exactly RD_LOW cycles. The word is captured at the clock edge on which the strobe rises.
- R6: Chip-select is low whenever a read strobe is low. Consecutive read strobes in a burst are separated by at least RD_HIGH high cycles.
- R7: Each captured word gives a one-cycle valid pulse, with channel index 0 for the first word counting up to NWORDS-1. A one-cycle done pulse follows RD_HIGH cycles after the last valid.
- R8: A convert-start never falls earlier than RELEASE+QUIET cycles after the last read strobe of the previous burst rose.
- R9: A convert-start never falls earlier than ACQ cycles after the previous conversion's busy fall.
- R10: A one-cycle start pulse, whether given while idle or during a conversion, is remembered and yields exactly one conversion. While the continuous input is high, conversions repeat with no slack beyond the interval rules.
- R11: A write drives the request's data with chip-select low for WR_SU cycles before the write strobe falls. The strobe stays low WR_LOW cycles, and data and chip-select are held WR_HD cycles after it rises. The driver then turns off.
- R12: A pending write is served before a pending conversion, and only while the bus is idle. It never overlaps a read burst or a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one conversion (pulse) |
| cont_i | input | 1 | Continuous conversion mode while high |
| wr_req_i | input | 1 | Request one register write (pulse) |
| wr_data_i | input | DW | Data for the requested write |
| adc_busy_i | input | 1 | Converter busy flag, synchronous |
| adc_db_i | input | DW | Parallel data bus, read direction |
| adc_db_o | output | DW | Parallel data bus, write direction |
| adc_db_oe_o | output | 1 | Bus driver enable for writes |
| adc_cs_n_o | output | 1 | Chip-select, active low |
| adc_rd_n_o | output | 1 | Read strobe, active low |
| adc_wr_n_o | output | 1 | Write strobe, active low |
| adc_cnv_n_o | output | 1 | Convert-start, low pulse, rising edge launches |
| word_valid_o | output | 1 | One-cycle pulse per result word |
| word_data_o | output | DW | Captured result word |
| word_ch_o | output | CHW | Channel index of the word |
| done_o | output | 1 | One-cycle pulse after the last word |
| busy_to_err_o | output | 1 | One-cycle busy-timeout error pulse |

## Verification
The bench builds the sequencer with NWORDS set to 3 and every timing count at its default. It models a converter whose busy flag rises two cycles after the launch and stays high for twenty cycles. With these values the acquisition count is the binding interval in continuous mode, so the exact launch-to-launch spacing can be checked against ACQ. The short three-word burst keeps the quiet-interval margin measurable. The busy timeout is reached by turning off the model's busy response.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CNV,
        S_BHI,
        S_BLO,
        S_RDL,
        S_RDH,
        S_WSU,
        S_WLO,
        S_WHD
    } seq_st_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_seq_gap.sv
// Minimum-interval tracker: counts cycles since the last mark and
// saturates at N; ok_o is high once N cycles have elapsed.
module adc_seq_gap #(
    parameter int N = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mark_i,
    output logic ok_o
);
    localparam int W = $clog2(N + 2);
    localparam logic [W-1:0] LIM = W'(N);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (mark_i)
            cnt_d = '0;
        else if (cnt_q != LIM)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= LIM;
        else        cnt_q <= cnt_d;
    end

    assign ok_o = (cnt_q == LIM);

    // R8/R9: the interval counter never runs past its limit
    p_gap_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int DW       = 16,
    parameter int NWORDS   = 4,
    parameter int CHW      = (NWORDS > 1) ? $clog2(NWORDS) : 1,
    parameter int CONV_LOW = 3,
    parameter int BUSY_TO  = 6,
    parameter int RD_LOW   = 5,
    parameter int RD_HIGH  = 1,
    parameter int RELEASE  = 2,
    parameter int QUIET    = 15,
    parameter int ACQ      = 55,
    parameter int WR_SU    = 1,
    parameter int WR_LOW   = 2,
    parameter int WR_HD    = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic           cont_i,
    input  logic           wr_req_i,
    input  logic [DW-1:0]  wr_data_i,
    input  logic           adc_busy_i,
    input  logic [DW-1:0]  adc_db_i,
    output logic [DW-1:0]  adc_db_o,
    output logic           adc_db_oe_o,
    output logic           adc_cs_n_o,
    output logic           adc_rd_n_o,
    output logic           adc_wr_n_o,
    output logic           adc_cnv_n_o,
    output logic           word_valid_o,
    output logic [DW-1:0]  word_data_o,
    output logic [CHW-1:0] word_ch_o,
    output logic           done_o,
    output logic           busy_to_err_o
);
    localparam int MAXC = max2(max2(max2(CONV_LOW, BUSY_TO), max2(RD_LOW, RD_HIGH)),
                               max2(max2(WR_SU, WR_LOW), WR_HD));
    localparam int CW = $clog2(MAXC + 1);

    localparam logic [CW-1:0]  C_CNV  = CW'(CONV_LOW - 1);
    localparam logic [CW-1:0]  C_BTO  = CW'(BUSY_TO - 1);
    localparam logic [CW-1:0]  C_RDL  = CW'(RD_LOW - 1);
    localparam logic [CW-1:0]  C_RDH  = CW'(RD_HIGH - 1);
    localparam logic [CW-1:0]  C_WSU  = CW'(WR_SU - 1);
    localparam logic [CW-1:0]  C_WLO  = CW'(WR_LOW - 1);
    localparam logic [CW-1:0]  C_WHD  = CW'(WR_HD - 1);
    localparam logic [CHW-1:0] LAST_W = CHW'(NWORDS - 1);

    typedef struct packed {
        seq_st_e        st;
        logic [CW-1:0]  cnt;
        logic [CHW-1:0] idx;
        logic           conv_pend;
        logic           wr_pend;
        logic [DW-1:0]  wr_word;
        logic           cnv_n;
        logic           cs_n;
        logic           rd_n;
        logic           wr_n;
        logic           oe;
        logic [DW-1:0]  dout;
        logic           valid;
        logic [DW-1:0]  word;
        logic [CHW-1:0] ch;
        logic           done;
        logic           err;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic      mark_quiet_d, mark_acq_d;
    logic      quiet_ok, acq_ok;

    adc_seq_gap #(.N(RELEASE + QUIET)) u_quiet (
        .clk(clk), .rst_n(rst_n), .mark_i(mark_quiet_d), .ok_o(quiet_ok)
    );

    adc_seq_gap #(.N(ACQ)) u_acq (
        .clk(clk), .rst_n(rst_n), .mark_i(mark_acq_d), .ok_o(acq_ok)
    );

    always_comb begin
        r_d          = r_q;
        r_d.valid    = 1'b0;
        r_d.done     = 1'b0;
        r_d.err      = 1'b0;
        mark_quiet_d = 1'b0;
        mark_acq_d   = 1'b0;

        unique case (r_q.st)
            S_IDLE: begin
                if (r_q.wr_pend) begin
                    r_d.st      = S_WSU;
                    r_d.wr_pend = 1'b0;
                    r_d.cs_n    = 1'b0;
                    r_d.oe      = 1'b1;
                    r_d.dout    = r_q.wr_word;
                    r_d.cnt     = '0;
                end else if ((r_q.conv_pend || cont_i) && quiet_ok && acq_ok) begin
                    r_d.st        = S_CNV;
                    r_d.conv_pend = 1'b0;
                    r_d.cnv_n     = 1'b0;
                    r_d.cnt       = '0;
                end
            end
            S_CNV: begin
                if (r_q.cnt == C_CNV) begin
                    r_d.cnv_n = 1'b1;
                    r_d.st    = S_BHI;
                    r_d.cnt   = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            S_BHI: begin
                if (adc_busy_i) begin
                    r_d.st = S_BLO;
                end else if (r_q.cnt == C_BTO) begin
                    r_d.err = 1'b1;
                    r_d.st  = S_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            S_BLO: begin
                if (!adc_busy_i) begin
                    mark_acq_d = 1'b1;
                    r_d.st     = S_RDL;
                    r_d.cs_n   = 1'b0;
                    r_d.rd_n   = 1'b0;
                    r_d.cnt    = '0;
                    r_d.idx    = '0;
                end
            end
            S_RDL: begin
                if (r_q.cnt == C_RDL) begin
                    r_d.rd_n  = 1'b1;
                    r_d.valid = 1'b1;
                    r_d.word  = adc_db_i;
                    r_d.ch    = r_q.idx;
                    r_d.st    = S_RDH;
                    r_d.cnt   = '0;
                    mark_quiet_d = (r_q.idx == LAST_W);
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            S_RDH: begin
                if (r_q.cnt == C_RDH) begin
                    r_d.cnt = '0;
                    if (r_q.idx == LAST_W) begin
                        r_d.cs_n = 1'b1;
                        r_d.done = 1'b1;
                        r_d.st   = S_IDLE;
                    end else begin
                        r_d.idx  = r_q.idx + 1'b1;
                        r_d.rd_n = 1'b0;
                        r_d.st   = S_RDL;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            S_WSU: begin
                if (r_q.cnt == C_WSU) begin
                    r_d.wr_n = 1'b0;
                    r_d.st   = S_WLO;
                    r_d.cnt  = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            S_WLO: begin
                if (r_q.cnt == C_WLO) begin
                    r_d.wr_n = 1'b1;
                    r_d.st   = S_WHD;
                    r_d.cnt  = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            S_WHD: begin
                if (r_q.cnt == C_WHD) begin
                    r_d.cs_n = 1'b1;
                    r_d.oe   = 1'b0;
                    r_d.st   = S_IDLE;
                    r_d.cnt  = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d.st = S_IDLE;
        endcase

        // Requests are captured after the case so a request arriving in
        // the cycle its predecessor is consumed is not lost.
        if (start_i) r_d.conv_pend = 1'b1;
        if (wr_req_i) begin
            r_d.wr_pend = 1'b1;
            r_d.wr_word = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= S_IDLE;
            r_q.cnv_n <= 1'b1;
            r_q.cs_n  <= 1'b1;
            r_q.rd_n  <= 1'b1;
            r_q.wr_n  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign adc_db_o      = r_q.dout;
    assign adc_db_oe_o   = r_q.oe;
    assign adc_cs_n_o    = r_q.cs_n;
    assign adc_rd_n_o    = r_q.rd_n;
    assign adc_wr_n_o    = r_q.wr_n;
    assign adc_cnv_n_o   = r_q.cnv_n;
    assign word_valid_o  = r_q.valid;
    assign word_data_o   = r_q.word;
    assign word_ch_o     = r_q.ch;
    assign done_o        = r_q.done;
    assign busy_to_err_o = r_q.err;

    p_rd_in_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_rd_n_o |-> !adc_cs_n_o);

    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |=> !word_valid_o);

    p_ch_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |-> (word_ch_o <= LAST_W));

    p_err_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_to_err_o |=> !busy_to_err_o);

    p_wr_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_wr_n_o |-> (adc_db_oe_o && !adc_cs_n_o && adc_rd_n_o));

    p_cnv_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cnv_n_o) |-> (quiet_ok && acq_ok && !adc_db_oe_o));

endmodule

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
    localparam int DW = 16, NW = 3, CHW = 2;
    localparam int CONV_LOW = 3, BUSY_TO = 6, RD_LOW = 5, RD_HIGH = 1;
    localparam int RELEASE = 2, QUIET = 15, ACQ = 55;
    localparam int WR_SU = 1, WR_LOW = 2, WR_HD = 1;
    localparam int CONV_CYC = 20;
    localparam int WD_LIMIT = 60000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, cont = 1'b0, wr_req = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic busy = 1'b0;
    logic [7:0] conv_no = '0, rd_no = '0;
    logic [DW-1:0] db_in, db_out, wdata;
    logic oe, cs_n, rd_n, wr_n, cnv_n, wvalid, done, err;
    logic [CHW-1:0] wch;

    assign db_in = {conv_no, rd_no};

    adc_seq_ctrl #(
        .DW(DW), .NWORDS(NW), .CHW(CHW), .CONV_LOW(CONV_LOW), .BUSY_TO(BUSY_TO),
        .RD_LOW(RD_LOW), .RD_HIGH(RD_HIGH), .RELEASE(RELEASE), .QUIET(QUIET),
        .ACQ(ACQ), .WR_SU(WR_SU), .WR_LOW(WR_LOW), .WR_HD(WR_HD)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cont_i(cont),
        .wr_req_i(wr_req), .wr_data_i(wr_data), .adc_busy_i(busy),
        .adc_db_i(db_in), .adc_db_o(db_out), .adc_db_oe_o(oe),
        .adc_cs_n_o(cs_n), .adc_rd_n_o(rd_n), .adc_wr_n_o(wr_n),
        .adc_cnv_n_o(cnv_n), .word_valid_o(wvalid), .word_data_o(wdata),
        .word_ch_o(wch), .done_o(done), .busy_to_err_o(err)
    );

    always #4 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Monitor state and converter model
    bit busy_en = 1'b1;
    bit prev_cnv = 1, prev_rd = 1, prev_wr = 1, prev_oe = 0, prev_cs = 1;
    bit have_rd = 0, have_bf = 0;
    int conv_t = 0, exp_ch = 0;
    int cnv_fall_t = 0, cnv_rise_t = 0, busy_fall_t = 0, rd_fall_t = 0, last_rd_rise = 0;
    int last_valid = 0, oe_rise_t = 0, wr_fall_t = 0, wr_rise_t = 0, wr_end_t = 0;
    int n_cnv = 0, n_valid = 0, n_done = 0, n_err = 0, n_wr = 0, acq_gap = 0;
    logic [DW-1:0] exp_wr = '0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (cyc > WD_LIMIT) begin
            chk(1'b0, "watchdog R1..all", cyc, WD_LIMIT);
            summary();
        end
        if (rst_n) begin
            if (wvalid) begin
                chk(int'(wch) == exp_ch, "R7 channel index", int'(wch), exp_ch);
                chk(wdata == {conv_no, rd_no}, "R5 captured word", int'(wdata), int'({conv_no, rd_no}));
                exp_ch++; last_valid = cyc; n_valid++;
            end
            if (done) begin
                chk(cyc - last_valid == RD_HIGH, "R7 done delay", cyc - last_valid, RD_HIGH);
                chk(exp_ch == NW, "R7 words before done", exp_ch, NW);
                n_done++;
            end
            if (err) begin
                chk(cyc - cnv_rise_t == BUSY_TO, "R3 timeout delay", cyc - cnv_rise_t, BUSY_TO);
                n_err++;
            end
            if (prev_cnv && !cnv_n) begin
                cnv_fall_t = cyc; n_cnv++; exp_ch = 0;
                if (have_rd) chk(cyc - last_rd_rise >= RELEASE + QUIET, "R8 quiet interval",
                                 cyc - last_rd_rise, RELEASE + QUIET);
                if (have_bf) begin
                    acq_gap = cyc - busy_fall_t;
                    chk(acq_gap >= ACQ, "R9 acquisition interval", acq_gap, ACQ);
                end
                chk(!oe && cs_n, "R12 bus idle at convert", int'(oe), 0);
            end
            if (!prev_cnv && cnv_n) begin
                chk(cyc - cnv_fall_t == CONV_LOW, "R2 convert pulse width", cyc - cnv_fall_t, CONV_LOW);
                cnv_rise_t = cyc; conv_no++; rd_no = '0;
                if (busy_en) conv_t = 1;
            end
            if (!rd_n && cs_n) chk(1'b0, "R6 read without chip-select", int'(cs_n), 0);
            if (prev_rd && !rd_n) begin
                rd_fall_t = cyc;
                if (rd_no == 0) chk(cyc - busy_fall_t == 1, "R4 read start", cyc - busy_fall_t, 1);
                else chk(cyc - last_rd_rise >= RD_HIGH, "R6 strobe gap", cyc - last_rd_rise, RD_HIGH);
            end
            if (!prev_rd && rd_n) begin
                chk(cyc - rd_fall_t == RD_LOW, "R5 read strobe width", cyc - rd_fall_t, RD_LOW);
                last_rd_rise = cyc; have_rd = 1; rd_no++;
            end
            if (!prev_oe && oe) begin
                oe_rise_t = cyc;
                chk(prev_cs && rd_n && cnv_n, "R12 write starts on idle bus", int'(prev_cs), 1);
            end
            if (prev_wr && !wr_n) begin
                chk(cyc - oe_rise_t == WR_SU, "R11 setup", cyc - oe_rise_t, WR_SU);
                chk(!cs_n && oe && db_out == exp_wr, "R11 data at strobe", int'(db_out), int'(exp_wr));
                wr_fall_t = cyc;
            end
            if (!prev_wr && wr_n) begin
                chk(cyc - wr_fall_t == WR_LOW, "R11 strobe width", cyc - wr_fall_t, WR_LOW);
                chk(db_out == exp_wr && !cs_n, "R11 data after strobe", int'(db_out), int'(exp_wr));
                wr_rise_t = cyc;
            end
            if (prev_oe && !oe) begin
                chk(cyc - wr_rise_t == WR_HD, "R11 hold", cyc - wr_rise_t, WR_HD);
                chk(cs_n, "R11 chip-select release", int'(cs_n), 1);
                n_wr++; wr_end_t = cyc;
            end
            if (conv_t > 0) begin
                conv_t++;
                if (conv_t == 3) busy = 1'b1;
                if (conv_t == 3 + CONV_CYC) begin
                    busy = 1'b0; busy_fall_t = cyc; have_bf = 1; conv_t = 0;
                end
            end
            prev_cnv = cnv_n; prev_rd = rd_n; prev_wr = wr_n; prev_oe = oe; prev_cs = cs_n;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic pulse_write(input logic [DW-1:0] v);
        @(negedge clk); wr_req = 1'b1; wr_data = v; exp_wr = v;
        @(negedge clk); wr_req = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(5);
        chk(cnv_n && cs_n && rd_n && wr_n, "R1 strobes high in reset", int'({cnv_n, cs_n, rd_n, wr_n}), 15);
        chk(!oe && !wvalid && !done && !err, "R1 outputs quiet in reset", int'({oe, wvalid, done, err}), 0);
        @(negedge clk); rst_n = 1'b1;
        idle(3);
        chk(cnv_n && cs_n && !oe, "R1 idle after reset", int'({cnv_n, cs_n, oe}), 6);
    endtask

    task automatic t_single();
        int c0 = n_cnv, v0 = n_valid, d0 = n_done;
        pulse_start();
        for (int i = 0; i < 500 && n_done == d0; i++) @(negedge clk);
        idle(150);
        chk(n_cnv - c0 == 1, "R10 one conversion per start", n_cnv - c0, 1);
        chk(n_valid - v0 == NW, "R7 word count", n_valid - v0, NW);
        chk(n_done - d0 == 1, "R7 one done pulse", n_done - d0, 1);
    endtask

    task automatic t_cont();
        int c0 = n_cnv;
        @(negedge clk); cont = 1'b1;
        for (int i = 0; i < 2000 && n_cnv - c0 < 4; i++) @(negedge clk);
        chk(acq_gap == ACQ + 2, "R10 continuous back-to-back spacing", acq_gap, ACQ + 2);
        cont = 1'b0;
        idle(200);
        chk(n_cnv - c0 <= 5, "R10 stops after continuous drops", n_cnv - c0, 5);
        c0 = n_cnv;
        idle(150);
        chk(n_cnv == c0, "R10 no conversion when idle", n_cnv, c0);
    endtask

    task automatic t_timeout();
        int e0 = n_err, v0 = n_valid;
        busy_en = 1'b0;
        pulse_start();
        idle(40);
        chk(n_err - e0 == 1, "R3 timeout flagged", n_err - e0, 1);
        chk(n_valid == v0, "R3 no reads after timeout", n_valid - v0, 0);
        chk(cs_n && rd_n, "R3 back to idle", int'({cs_n, rd_n}), 3);
        busy_en = 1'b1;
        idle(80);
    endtask

    task automatic t_write();
        int w0 = n_wr;
        pulse_write(16'hA5C3);
        idle(20);
        chk(n_wr - w0 == 1, "R11 write completed", n_wr - w0, 1);
        chk(!oe && cs_n && wr_n, "R11 driver off after write", int'(oe), 0);
    endtask

    task automatic t_priority();
        int w0 = n_wr, c0 = n_cnv, d0 = n_done;
        @(negedge clk); start = 1'b1; wr_req = 1'b1; wr_data = 16'h3C5A; exp_wr = 16'h3C5A;
        @(negedge clk); start = 1'b0; wr_req = 1'b0;
        for (int i = 0; i < 500 && n_done == d0; i++) @(negedge clk);
        chk(n_wr - w0 == 1 && n_cnv - c0 == 1, "R12 both served", n_wr - w0, 1);
        chk(wr_end_t <= cnv_fall_t, "R12 write before conversion", wr_end_t, cnv_fall_t);
        idle(100);
        // write and start requested while a conversion is running
        d0 = n_done; w0 = n_wr; c0 = n_cnv;
        pulse_start();
        idle(8);
        pulse_write(16'h0F0F);
        pulse_start();
        for (int i = 0; i < 1000 && n_done - d0 < 2; i++) @(negedge clk);
        idle(20);
        chk(n_wr - w0 == 1, "R12 deferred write served", n_wr - w0, 1);
        chk(n_cnv - c0 == 2, "R10 start during conversion kept", n_cnv - c0, 2);
        chk(n_done - d0 == 2, "R7 two bursts done", n_done - d0, 2);
    endtask

    initial begin
        t_reset();
        t_single();
        t_write();
        t_cont();
        t_timeout();
        t_single();
        t_priority();
        idle(20);
        summary();
    end

endmodule